// File: doc/BRIEF.md
# Up-Counting Timer with Asynchronous External Clear

This block is a 16-bit up-counter with a programmable compare value, a two-bit mode control and a level-sensitive external clear input. The counter advances once for each qualified timer tick. A tick is a one-clock enable pulse supplied by the clock divider, for example every fourth oscillator cycle. When the count equals the compare value, the next tick wraps the count to zero, sets a sticky match flag and raises a one-cycle match pulse.

While the external clear input is high, the count is zero and the flag is clear, without waiting for a clock edge. This lets software line the timer up with an outside event, such as a shaft sensor or a frame strobe. The release of the clear passes through a synchronizer, so counting restarts cleanly from zero. A halt input freezes counting and stands in for a stopped clock.

Startup follows a two-step sequence. First, write initialize=1 and run=0 to clear and arm the timer. Then write initialize=1 and run=1 to start it. If the arming step is skipped, the first qualified tick is spent priming the counter and is not counted.

A four-state machine sets the mode. The states are IDLE (stopped, count held), ARMED (cleared, waiting to start), PRIMING (started without arming, waiting for one tick to waste) and RUNNING (counting). Any control write with run=0 leads to ARMED when initialize=1, or to IDLE when initialize=0. A control write with run=1 leads from ARMED or RUNNING to RUNNING, and from IDLE or PRIMING to PRIMING. With no write, PRIMING moves to RUNNING on its first qualified tick. Every other state holds.

Top module: `ext_sync_timer`

## Requirements
- R1: After rst_n is low, count is 0x0000, flag and match_pulse are 0, the compare value is 0xFFFF and the state is IDLE, so ticks do not advance the count.
- R2: A control write with ctl_init=1 and ctl_run=0 clears count and flag at that clock edge, and the count then stays at zero on later ticks.
- R3: A control write with ctl_init=1 and ctl_run=1 issued from ARMED does not count a tick present in the write cycle. The first tick after it advances the count to 0x0001.
- R4: A control write with ctl_run=1 issued from IDLE leaves the count unchanged and does not count the next qualified tick. Each tick after that one advances the count.
- R5: In RUNNING, the count rises by exactly one at each clock edge where tick=1, and holds where tick=0.
- R6: While halt=1, ticks are ignored and the count holds.
- R7: A qualified tick taken while count equals the compare value sets count to 0x0000 and flag to 1, and raises match_pulse for one clock cycle.
- R8: The flag stays at 1 across later ticks until a control write with ctl_init=1 or an external clear.
- R9: While ext_clr=1, count reads 0x0000 and flag reads 0, including before any clock edge.
- R10: After ext_clr falls, ticks at the first two clock edges are ignored, and the tick at the third edge gives count 0x0001.
- R11: A control write with ctl_init=0 and ctl_run=0 stops the timer and keeps the count, which then ignores ticks.
- R12: A write with cmp_wr=1 loads cmp_data as the new compare value, which takes effect for the following ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timer tick enable, one clock wide |
| halt | input | 1 | Freezes counting (stands in for a stopped clock) |
| ctl_wr | input | 1 | Control write strobe |
| ctl_init | input | 1 | Initialize bit of the control write |
| ctl_run | input | 1 | Run bit of the control write |
| cmp_wr | input | 1 | Compare register write strobe |
| cmp_data | input | 16 | New compare value |
| ext_clr | input | 1 | Asynchronous level clear of the count and flag |
| count | output | 16 | Current count |
| match_pulse | output | 1 | One-cycle pulse on compare wrap |
| flag | output | 1 | Sticky match flag |

## Verification
A wrong mode state shows on count within one tick. A stuck IDLE or ARMED state freezes the count at the first tick after a start write. A missing PRIMING state shows as a count one too high after an unarmed start. A synchronizer that is too short or too long moves the first count after a clear release by one clock edge, so the bench checks the count at each of the three edges that follow. A compare or flag fault shows at the wrap tick through match_pulse, flag and a count that fails to return to zero.

// File: rtl/ext_sync_timer_pkg.sv
package ext_sync_timer_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_PRIMING = 2'd2,
        ST_RUNNING = 2'd3
    } tmr_state_e;
endpackage

// File: rtl/ext_clr_release_sync.sv
module ext_clr_release_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_clr,
    output logic hold
);
    logic [STAGES-1:0] sr;

    // assertion is immediate (async set); release ripples through STAGES flops
    always_ff @(posedge clk or negedge rst_n or posedge ext_clr) begin
        if (!rst_n) begin
            sr <= '0;
        end else if (ext_clr) begin
            sr <= '1;
        end else begin
            sr <= {sr[STAGES-2:0], 1'b0};
        end
    end

    assign hold = sr[STAGES-1];
endmodule

// File: rtl/tmr_mode_fsm.sv
module tmr_mode_fsm
    import ext_sync_timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr,
    input  logic ctl_init,
    input  logic ctl_run,
    input  logic tick_ok,
    output logic step,
    output logic clear
);
    tmr_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (ctl_wr) begin
            if (!ctl_run) begin
                state_nx = ctl_init ? ST_ARMED : ST_IDLE;
            end else begin
                unique case (state)
                    ST_ARMED, ST_RUNNING: state_nx = ST_RUNNING;
                    ST_IDLE, ST_PRIMING:  state_nx = ST_PRIMING;
                    default:              state_nx = ST_IDLE;
                endcase
            end
        end else if (state == ST_PRIMING && tick_ok) begin
            state_nx = ST_RUNNING;
        end
    end

    always_comb begin
        step  = (state == ST_RUNNING) && tick_ok;
        clear = ctl_wr && ctl_init;
    end

    // R4: the wasted priming tick always leads into counting
    assert_prime_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PRIMING && tick_ok && !ctl_wr) |=> (state == ST_RUNNING));
    // R11: a stop write always lands in IDLE
    assert_stop_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !ctl_run && !ctl_init) |=> (state == ST_IDLE));
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
    parameter int          W        = 16,
    parameter logic [W-1:0] CMP_INIT = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ext_clr,
    input  logic         step,
    input  logic         clear,
    input  logic         cmp_wr,
    input  logic [W-1:0] cmp_data,
    output logic [W-1:0] count,
    output logic         match_pulse,
    output logic         flag
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cmp_q;
    logic         at_cmp;

    assign at_cmp = (count == cmp_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cmp_q <= CMP_INIT;
        else if (cmp_wr) cmp_q <= cmp_data;
    end

    always_ff @(posedge clk or negedge rst_n or posedge ext_clr) begin
        if (!rst_n || ext_clr) begin
            count       <= '0;
            flag        <= 1'b0;
            match_pulse <= 1'b0;
        end else if (clear) begin
            count       <= '0;
            flag        <= 1'b0;
            match_pulse <= 1'b0;
        end else begin
            match_pulse <= step && at_cmp;
            if (step) count <= at_cmp ? '0 : count + ONE;
            if (step && at_cmp) flag <= 1'b1;
        end
    end

    assert_match_wraps_R7: assert property (@(posedge clk) disable iff (!rst_n || ext_clr)
        match_pulse |-> (count == '0 && flag));
    assert_step_increments_R5: assert property (@(posedge clk) disable iff (!rst_n || ext_clr)
        (step && !clear && !at_cmp) |=> (count == $past(count) + ONE));
    assert_idle_holds_R6: assert property (@(posedge clk) disable iff (!rst_n || ext_clr)
        (!step && !clear) |=> $stable(count));
    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n || ext_clr)
        (flag && !clear) |=> flag);
endmodule

// File: rtl/ext_sync_timer.sv
module ext_sync_timer #(
    parameter int           W           = 16,
    parameter int           SYNC_STAGES = 2,
    parameter logic [W-1:0] CMP_INIT    = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         halt,
    input  logic         ctl_wr,
    input  logic         ctl_init,
    input  logic         ctl_run,
    input  logic         cmp_wr,
    input  logic [W-1:0] cmp_data,
    input  logic         ext_clr,
    output logic [W-1:0] count,
    output logic         match_pulse,
    output logic         flag
);
    logic hold;
    logic tick_ok;
    logic step;
    logic clear;

    ext_clr_release_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .ext_clr (ext_clr),
        .hold    (hold)
    );

    assign tick_ok = tick && !halt && !hold;

    tmr_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_wr   (ctl_wr),
        .ctl_init (ctl_init),
        .ctl_run  (ctl_run),
        .tick_ok  (tick_ok),
        .step     (step),
        .clear    (clear)
    );

    tmr_count_core #(.W(W), .CMP_INIT(CMP_INIT)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_clr     (ext_clr),
        .step        (step),
        .clear       (clear),
        .cmp_wr      (cmp_wr),
        .cmp_data    (cmp_data),
        .count       (count),
        .match_pulse (match_pulse),
        .flag        (flag)
    );

    assert_clr_forces_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ext_clr |-> (count == '0 && !flag && !match_pulse));
    assert_release_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (count == '0));
endmodule

// File: tb/test_ext_sync_timer.sv
`timescale 1ns/1ps
module test_ext_sync_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0, halt = 1'b0;
    logic        ctl_wr = 1'b0, ctl_init = 1'b0, ctl_run = 1'b0;
    logic        cmp_wr = 1'b0;
    logic [15:0] cmp_data = '0;
    logic        ext_clr = 1'b0;
    logic [15:0] count;
    logic        match_pulse, flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ext_sync_timer i_ext_sync_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .halt(halt),
        .ctl_wr(ctl_wr), .ctl_init(ctl_init), .ctl_run(ctl_run),
        .cmp_wr(cmp_wr), .cmp_data(cmp_data), .ext_clr(ext_clr),
        .count(count), .match_pulse(match_pulse), .flag(flag)
    );

    // vector: {wr, init, run, tick, halt, expected count}
    localparam int NV = 15;
    localparam logic [20:0] VEC [0:NV-1] = '{
        {5'b00010, 16'd0},  // R1 idle ignores tick
        {5'b11010, 16'd0},  // R2 arm write
        {5'b00010, 16'd0},  // R2 armed, no count
        {5'b11110, 16'd0},  // R3 start write, tick not counted
        {5'b00010, 16'd1},  // R3 first tick counts
        {5'b00000, 16'd1},  // R5 no tick holds
        {5'b00010, 16'd2},  // R5
        {5'b00011, 16'd2},  // R6 halted
        {5'b00010, 16'd3},  // R5
        {5'b10000, 16'd3},  // R11 stop write
        {5'b00010, 16'd3},  // R11 stopped
        {5'b10100, 16'd3},  // R4 unarmed start
        {5'b00010, 16'd3},  // R4 priming tick lost
        {5'b00010, 16'd4},  // R4 counting
        {5'b11000, 16'd0}   // R2 arm clears
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // assumes caller is at a negedge; applies inputs over one posedge
    task automatic cyc(input logic w, input logic i, input logic r, input logic t, input logic h);
        ctl_wr = w; ctl_init = i; ctl_run = r; tick = t; halt = h;
        @(posedge clk);
        @(negedge clk);
        ctl_wr = 1'b0; tick = 1'b0; halt = 1'b0;
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        chk("R1 count", count, 16'h0000);
        chk("R1 flag", {15'd0, flag}, 16'd0);
        chk("R1 match", {15'd0, match_pulse}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < NV; k++) begin
            cyc(VEC[k][20], VEC[k][19], VEC[k][18], VEC[k][17], VEC[k][16]);
            chk($sformatf("vector %0d", k), count, VEC[k][15:0]);
        end

        // R1 compare reset 0xFFFF: start and tick; no wrap near small counts
        // R12 load compare 2, R7 wrap
        cmp_data = 16'h0002; cmp_wr = 1'b1;
        @(posedge clk); @(negedge clk); cmp_wr = 1'b0;
        cyc(1, 1, 1, 0, 0);
        cyc(0, 0, 0, 1, 0); chk("R12 count1", count, 16'd1);
        cyc(0, 0, 0, 1, 0); chk("R12 count2", count, 16'd2);
        chk("R7 no early match", {15'd0, match_pulse}, 16'd0);
        cyc(0, 0, 0, 1, 0);
        chk("R7 wrap count", count, 16'd0);
        chk("R7 match pulse", {15'd0, match_pulse}, 16'd1);
        chk("R7 flag set", {15'd0, flag}, 16'd1);
        cyc(0, 0, 0, 0, 0);
        chk("R7 pulse one cycle", {15'd0, match_pulse}, 16'd0);
        chk("R8 flag held", {15'd0, flag}, 16'd1);
        cyc(0, 0, 0, 1, 0);
        chk("R8 flag after tick", {15'd0, flag}, 16'd1);
        chk("R5 count after wrap", count, 16'd1);

        // R9 async clear mid-cycle
        #1 ext_clr = 1'b1;
        #0.5;
        chk("R9 count async", count, 16'd0);
        chk("R9 flag async", {15'd0, flag}, 16'd0);
        @(negedge clk);
        cyc(0, 0, 0, 1, 0); chk("R9 held", count, 16'd0);
        ext_clr = 1'b0;
        cyc(0, 0, 0, 1, 0); chk("R10 edge1", count, 16'd0);
        cyc(0, 0, 0, 1, 0); chk("R10 edge2", count, 16'd0);
        cyc(0, 0, 0, 1, 0); chk("R10 edge3", count, 16'd1);

        // R8 flag cleared by init write
        cyc(0, 0, 0, 1, 0);
        cyc(0, 0, 0, 1, 0);
        chk("R7 second wrap", count, 16'd0);
        chk("R8 flag set again", {15'd0, flag}, 16'd1);
        cyc(1, 1, 0, 0, 0);
        chk("R8 flag cleared by init", {15'd0, flag}, 16'd0);
        chk("R2 count cleared", count, 16'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule